// File: doc/BRIEF.md
# Trap Cause Register Unit with Level-Interrupt Aliasing

This block keeps the trap cause registers of a small hart for two privilege levels, machine and user, behind a single-cycle CSR access port. Software writes go through a storage mask that keeps only the interrupt flag in the top bit and the exception-code bits that fit the configured interrupt count. A hardware trap-entry port can also load either cause register. That port wins over a software write in the same cycle.

The block owns three previous-state fields of the status register: machine previous interrupt enable, machine previous privilege and user previous interrupt enable. It reads the two low mode bits of the machine trap-vector register. When those bits equal 3, the level-interrupt controller mode is active. In that mode the cause registers act as windows onto the previous-state fields. The machine cause shows and loads the machine enable at bit 27 and the machine privilege at bits 29:28. The user cause shows and loads only the user enable at bit 27. In every other mode the cause registers are plain masked storage.

The same port also decodes two read-only registers. One is an interrupt-level status word, taken from an input. The other is a constant controller information word.

Top module: `trap_cause_csr`

## Requirements
- R1: After reset both stored cause values read as zero, and the three previous-state outputs are zero.
- R2: A stored cause keeps only bit XLEN-1 and bits log2(MAX_IRQ)-1:0 of the written value. With the defaults this is mask 0x8000_0FFF, and every other stored bit reads back as zero.
- R3: The controller mode is active only when tvec_mode equals 2'b11. With any other value, cause reads return the stored value alone and cause writes leave all previous-state outputs unchanged.
- R4: In controller mode, a read of the machine cause (address 0x342) returns the stored value OR machine enable at bit 27 OR machine privilege at bits 29:28.
- R5: In controller mode, a write to the machine cause sets the machine enable output from write-data bit 27 and the machine privilege output from write-data bits 29:28 at the next clock edge. The user enable is left unchanged.
- R6: Address bits 9:8 equal to 0 select the user cause at 0x042. In controller mode, a user cause read ORs in only the user enable at bit 27, and a write loads only the user enable from bit 27. The machine fields stay unchanged.
- R7: The interrupt status register at 0xFB1 reads back the lvl_status input. Writes to it are ignored and change no output or stored value.
- R8: The information register at 0xFC0 reads (4 << 21) + NUM_IRQ, which is 0x0080_0010 with the defaults. Writes to it are ignored.
- R9: An access with csr_en high to any other address returns zero read data and raises csr_illegal in the same cycle. csr_illegal is low for decoded addresses.
- R10: When trap_we is high, the cause register chosen by trap_priv (0 selects user, any other value selects machine) loads trap_cause through the R2 mask. Any software CSR write in that cycle is dropped completely, including its previous-state update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tvec_mode | input | 2 | Low two bits of the machine trap-vector register |
| csr_en | input | 1 | CSR access strobe |
| csr_we | input | 1 | CSR write qualifier |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data, combinational |
| csr_illegal | output | 1 | Access to an undecoded address |
| trap_we | input | 1 | Hardware trap-entry cause load |
| trap_priv | input | 2 | Target level of the trap load |
| trap_cause | input | XLEN | Cause value from trap entry |
| lvl_status | input | XLEN | Current interrupt-level word shown by the status register |
| prv_mpie | output | 1 | Machine previous interrupt enable |
| prv_mpp | output | 2 | Machine previous privilege |
| prv_upie | output | 1 | User previous interrupt enable |

## Verification
A corrupted stored cause appears at csr_rdata on the first read of that register. Read data is combinational, so the error shows in the same cycle as the access. A wrong previous-state field appears on the status outputs one edge after the write that set it. It is also visible in bits 27 to 29 of any cause read in controller mode. Toggling tvec_mode between reads of an unchanged register separates aliasing faults from storage faults.

// File: rtl/trap_cause_pkg.sv
package trap_cause_pkg;
  localparam logic [11:0] ADDR_MCAUSE = 12'h342;
  localparam logic [11:0] ADDR_UCAUSE = 12'h042;
  localparam logic [11:0] ADDR_LVLST  = 12'hFB1;
  localparam logic [11:0] ADDR_INFO   = 12'hFC0;
  localparam int PIE_BIT = 27;
  localparam int PP_LSB  = 28;
  localparam logic [1:0] MODE_LVL = 2'b11;

  function automatic logic [31:0] info_word(input int num_irq);
    return (32'd4 << 21) + 32'(num_irq);
  endfunction
endpackage

// File: rtl/cause_slot.sv
module cause_slot #(
  parameter int XLEN    = 32,
  parameter int MAX_IRQ = 4096
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_we,
  input  logic [XLEN-1:0] sw_data,
  input  logic            hw_we,
  input  logic [XLEN-1:0] hw_data,
  output logic [XLEN-1:0] q
);
  localparam logic [XLEN-1:0] KEEP = {1'b1, {(XLEN-1){1'b0}}} | XLEN'(MAX_IRQ - 1);

  logic            en;
  logic [XLEN-1:0] d;

  always_comb begin
    en = hw_we | sw_we;
    d  = (hw_we ? hw_data : sw_data) & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/prev_state_alias.sv
module prev_state_alias #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_m,
  input  logic            wr_u,
  input  logic [XLEN-1:0] wdata,
  output logic            mpie,
  output logic [1:0]      mpp,
  output logic            upie
);
  import trap_cause_pkg::*;

  logic       mpie_d, upie_d;
  logic [1:0] mpp_d;

  always_comb begin
    mpie_d = wr_m ? wdata[PIE_BIT] : mpie;
    mpp_d  = wr_m ? wdata[PP_LSB +: 2] : mpp;
    upie_d = wr_u ? wdata[PIE_BIT] : upie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpie <= 1'b0;
      mpp  <= 2'b00;
      upie <= 1'b0;
    end else begin
      mpie <= mpie_d;
      mpp  <= mpp_d;
      upie <= upie_d;
    end
  end
endmodule

// File: rtl/trap_cause_csr.sv
module trap_cause_csr #(
  parameter int XLEN    = 32,
  parameter int MAX_IRQ = 4096,
  parameter int NUM_IRQ = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      tvec_mode,
  input  logic            csr_en,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_illegal,
  input  logic            trap_we,
  input  logic [1:0]      trap_priv,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] lvl_status,
  output logic            prv_mpie,
  output logic [1:0]      prv_mpp,
  output logic            prv_upie
);
  import trap_cause_pkg::*;

  localparam int NLVL = 2;
  localparam logic [XLEN-1:0] INFO = XLEN'(info_word(NUM_IRQ));

  // reset: asserted asynchronously, released after two clean edges
  logic [1:0] rst_sync;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  logic            lvl_on;
  logic            sw_ok;
  logic [NLVL-1:0] hit_cause;
  logic            hit_lvlst, hit_info;
  logic [XLEN-1:0] cause_q [NLVL];

  always_comb begin
    lvl_on       = (tvec_mode == MODE_LVL);
    hit_cause[0] = (csr_addr == ADDR_UCAUSE);
    hit_cause[1] = (csr_addr == ADDR_MCAUSE);
    hit_lvlst    = (csr_addr == ADDR_LVLST);
    hit_info     = (csr_addr == ADDR_INFO);
    sw_ok        = csr_en & csr_we & ~trap_we;
  end

  // slot 0 = user level, slot 1 = machine level
  for (genvar g = 0; g < NLVL; g++) begin : g_slot
    logic hw_sel;
    assign hw_sel = trap_we & ((trap_priv == 2'b00) == (g == 0));
    cause_slot #(.XLEN(XLEN), .MAX_IRQ(MAX_IRQ)) u_slot (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .sw_we   (sw_ok & hit_cause[g]),
      .sw_data (csr_wdata),
      .hw_we   (hw_sel),
      .hw_data (trap_cause),
      .q       (cause_q[g])
    );
  end

  prev_state_alias #(.XLEN(XLEN)) u_alias (
    .clk   (clk),
    .rst_n (rst_core_n),
    .wr_m  (sw_ok & hit_cause[1] & lvl_on),
    .wr_u  (sw_ok & hit_cause[0] & lvl_on),
    .wdata (csr_wdata),
    .mpie  (prv_mpie),
    .mpp   (prv_mpp),
    .upie  (prv_upie)
  );

  logic [XLEN-1:0] m_view, u_view;
  always_comb begin
    m_view = cause_q[1];
    u_view = cause_q[0];
    if (lvl_on) begin
      m_view[PIE_BIT]     = m_view[PIE_BIT] | prv_mpie;
      m_view[PP_LSB +: 2] = m_view[PP_LSB +: 2] | prv_mpp;
      u_view[PIE_BIT]     = u_view[PIE_BIT] | prv_upie;
    end
    csr_rdata   = '0;
    csr_illegal = 1'b0;
    if (csr_en) begin
      unique case (1'b1)
        hit_cause[1]: csr_rdata = m_view;
        hit_cause[0]: csr_rdata = u_view;
        hit_lvlst:    csr_rdata = lvl_status;
        hit_info:     csr_rdata = INFO;
        default:      csr_illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/trap_cause_csr_chk.sv
module trap_cause_csr_chk #(
  parameter int XLEN    = 32,
  parameter int MAX_IRQ = 4096,
  parameter int NUM_IRQ = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      tvec_mode,
  input logic            csr_en,
  input logic            csr_we,
  input logic [11:0]     csr_addr,
  input logic [XLEN-1:0] csr_wdata,
  input logic [XLEN-1:0] csr_rdata,
  input logic            csr_illegal,
  input logic            trap_we,
  input logic [XLEN-1:0] lvl_status,
  input logic            prv_mpie,
  input logic [1:0]      prv_mpp,
  input logic            prv_upie
);
  import trap_cause_pkg::*;

  localparam logic [XLEN-1:0] KEEP = {1'b1, {(XLEN-1){1'b0}}} | XLEN'(MAX_IRQ - 1);

  logic known, cause_acc, plain_mode, sw_wr;
  assign known = (csr_addr == ADDR_MCAUSE) || (csr_addr == ADDR_UCAUSE) ||
                 (csr_addr == ADDR_LVLST)  || (csr_addr == ADDR_INFO);
  assign cause_acc  = (csr_addr == ADDR_MCAUSE) || (csr_addr == ADDR_UCAUSE);
  assign plain_mode = (tvec_mode != 2'b11);
  assign sw_wr      = csr_en && csr_we && !trap_we;

  assert_cause_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && cause_acc && plain_mode) |-> ((csr_rdata & ~KEEP) == '0));

  assert_plain_no_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_we && plain_mode) |=>
      ($stable(prv_mpie) && $stable(prv_mpp) && $stable(prv_upie)));

  assert_m_alias_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !plain_mode && csr_addr == ADDR_MCAUSE) |=>
      (prv_mpie == $past(csr_wdata[27]) && prv_mpp == $past(csr_wdata[29:28]) && $stable(prv_upie)));

  assert_u_alias_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !plain_mode && csr_addr == ADDR_UCAUSE) |=>
      (prv_upie == $past(csr_wdata[27]) && $stable(prv_mpie) && $stable(prv_mpp)));

  assert_lvlst_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_addr == ADDR_LVLST) |->
      (csr_rdata == lvl_status && !csr_illegal));

  assert_lvlst_wr_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_we && csr_addr == ADDR_LVLST) |=>
      ($stable(prv_mpie) && $stable(prv_mpp) && $stable(prv_upie)));

  assert_info_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_addr == ADDR_INFO) |-> (csr_rdata == XLEN'(info_word(NUM_IRQ))));

  assert_undecoded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && !known) |-> (csr_illegal && csr_rdata == '0));

  assert_trap_blocks_sw_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_we) |=> ($stable(prv_mpie) && $stable(prv_mpp) && $stable(prv_upie)));
endmodule

bind trap_cause_csr trap_cause_csr_chk #(.XLEN(XLEN), .MAX_IRQ(MAX_IRQ), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tvec_mode   (tvec_mode),
  .csr_en      (csr_en),
  .csr_we      (csr_we),
  .csr_addr    (csr_addr),
  .csr_wdata   (csr_wdata),
  .csr_rdata   (csr_rdata),
  .csr_illegal (csr_illegal),
  .trap_we     (trap_we),
  .lvl_status  (lvl_status),
  .prv_mpie    (prv_mpie),
  .prv_mpp     (prv_mpp),
  .prv_upie    (prv_upie)
);

// File: tb/tb_trap_cause_csr.sv
module tb_trap_cause_csr;
  localparam int XLEN = 32;
  localparam logic [31:0] LVL_WORD = 32'h5A00_00C3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      tvec_mode;
  logic            csr_en, csr_we;
  logic [11:0]     csr_addr;
  logic [XLEN-1:0] csr_wdata, csr_rdata;
  logic            csr_illegal;
  logic            trap_we;
  logic [1:0]      trap_priv;
  logic [XLEN-1:0] trap_cause;
  logic [XLEN-1:0] lvl_status;
  logic            prv_mpie, prv_upie;
  logic [1:0]      prv_mpp;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  trap_cause_csr #(.XLEN(XLEN), .MAX_IRQ(4096), .NUM_IRQ(16)) dut (
    .clk(clk), .rst_n(rst_n), .tvec_mode(tvec_mode),
    .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
    .trap_we(trap_we), .trap_priv(trap_priv), .trap_cause(trap_cause),
    .lvl_status(lvl_status), .prv_mpie(prv_mpie), .prv_mpp(prv_mpp),
    .prv_upie(prv_upie)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  mode;
    logic [11:0] addr;
    logic        we;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic        exp_ill;
    logic [3:0]  exp_st;   // {mpie, mpp[1:0], upie}
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 2'd0, 12'h342, 1'b0, 32'h0,         32'h0000_0000, 1'b0, 4'b0000}, // R1
    '{4'd2, 2'd0, 12'h342, 1'b1, 32'hFFFF_FFFF, 32'h8000_0FFF, 1'b0, 4'b0000}, // R2
    '{4'd3, 2'd0, 12'h042, 1'b1, 32'h3800_0123, 32'h0000_0123, 1'b0, 4'b0000}, // R3
    '{4'd5, 2'd3, 12'h342, 1'b1, 32'h3800_0005, 32'h3800_0005, 1'b0, 4'b1110}, // R5 + R4
    '{4'd3, 2'd0, 12'h342, 1'b0, 32'h0,         32'h0000_0005, 1'b0, 4'b1110}, // R3
    '{4'd6, 2'd3, 12'h042, 1'b1, 32'h3800_0456, 32'h0800_0456, 1'b0, 4'b1111}, // R6
    '{4'd5, 2'd3, 12'h342, 1'b1, 32'h1000_0000, 32'h1000_0000, 1'b0, 4'b0011}, // R5
    '{4'd6, 2'd3, 12'h042, 1'b1, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'b0010}, // R6
    '{4'd3, 2'd1, 12'h342, 1'b1, 32'h2800_0FFF, 32'h0000_0FFF, 1'b0, 4'b0010}, // R3
    '{4'd4, 2'd3, 12'h342, 1'b0, 32'h0,         32'h1000_0FFF, 1'b0, 4'b0010}, // R4
    '{4'd7, 2'd3, 12'hFB1, 1'b1, 32'hFFFF_FFFF, 32'h5A00_00C3, 1'b0, 4'b0010}, // R7
    '{4'd8, 2'd3, 12'hFC0, 1'b1, 32'h1234_5678, 32'h0080_0010, 1'b0, 4'b0010}, // R8
    '{4'd9, 2'd3, 12'h300, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 4'b0010}, // R9
    '{4'd9, 2'd3, 12'h142, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 4'b0010}  // R9
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_en = 1'b0; csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic [11:0] a, output logic [31:0] d, output logic ill);
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b0; csr_addr = a;
    #1;
    d = csr_rdata; ill = csr_illegal;
    @(negedge clk);
    csr_en = 1'b0;
  endtask

  function automatic logic [31:0] st_word();
    return {28'd0, prv_mpie, prv_mpp, prv_upie};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        ill;
    tvec_mode = 2'd0; csr_en = 0; csr_we = 0; csr_addr = '0; csr_wdata = '0;
    trap_we = 0; trap_priv = 2'd0; trap_cause = '0; lvl_status = LVL_WORD;
    do_reset();

    check("R1 status after reset", st_word(), 32'h0);
    tvec_mode = 2'd3;
    csr_read(12'h042, rd, ill);
    check("R1 user cause after reset", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      tvec_mode = VECS[i].mode;
      if (VECS[i].we) csr_write(VECS[i].addr, VECS[i].wd);
      csr_read(VECS[i].addr, rd, ill);
      check($sformatf("R%0d vec%0d rdata", VECS[i].req, i), rd, VECS[i].exp_rd);
      check($sformatf("R%0d vec%0d illegal", VECS[i].req, i), {31'd0, ill}, {31'd0, VECS[i].exp_ill});
      check($sformatf("R%0d vec%0d status", VECS[i].req, i), st_word(), {28'd0, VECS[i].exp_st});
    end

    // R10: trap load to machine level beats a software write in the same cycle
    tvec_mode = 2'd3;
    @(negedge clk);
    trap_we = 1'b1; trap_priv = 2'd3; trap_cause = 32'hFFFF_FFF7;
    csr_en = 1'b1; csr_we = 1'b1; csr_addr = 12'h342; csr_wdata = 32'h3800_0001;
    @(negedge clk);
    trap_we = 1'b0; csr_en = 1'b0; csr_we = 1'b0;
    check("R10 status untouched by dropped write", st_word(), 32'h2);
    csr_read(12'h342, rd, ill);
    check("R10 machine cause from trap port", rd, 32'h9000_0FF7);

    // R10: trap load to user level, read in plain mode
    @(negedge clk);
    trap_we = 1'b1; trap_priv = 2'd0; trap_cause = 32'h0000_F033;
    @(negedge clk);
    trap_we = 1'b0;
    tvec_mode = 2'd0;
    csr_read(12'h042, rd, ill);
    check("R10 user cause from trap port", rd, 32'h0000_0033);
    csr_read(12'h342, rd, ill);
    check("R10 machine cause kept", rd, 32'h8000_0FF7);

    // R1: reset in mid-run
    do_reset();
    check("R1 status after second reset", st_word(), 32'h0);
    tvec_mode = 2'd3;
    csr_read(12'h342, rd, ill);
    check("R1 machine cause after second reset", rd, 32'h0);
    csr_read(12'h042, rd, ill);
    check("R1 user cause after second reset", rd, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule